// File: doc/BRIEF.md
# Ethernet Port Status LED Driver

This block turns the status of one 10/100 Ethernet port into drive levels for its indicator LEDs. Its inputs are the link, speed and duplex levels and single-cycle pulses for transmit, receive and collision. Its outputs are four active-low LED pins. A mode input picks one of two mappings. In the three-LED mapping, steady status and a blink share a pin: the link LED blinks for activity and the duplex LED blinks for collisions. In the four-LED mapping, speed and link are split across two LEDs and activity has a pin of its own.

Any short event opens a stretch window of one full blink period, so a single-cycle pulse still gives one complete, visible blink. Another event inside the window extends the window but leaves the blink phase running. The blink rates come from a clock-frequency parameter. Activity uses a slow rate (10 Hz by default) and collisions a rate twice as fast (20 Hz).

Top module: `led_status_ctrl`

## Requirements
- R1: While reset is asserted, all four `led_n` outputs are high (off). They stay high until the first clock edge after reset is released.
- R2: In 3-LED mode (`mode_4led`=0), `led_n[0]` is low exactly when `link_up` and `speed_100` are both 1.
- R3: In 3-LED mode, `led_n[1]` is low while the link is up and no activity window is open. While an activity window is open, `led_n[1]` is low for the first half period, high for the second half, and so on, starting the cycle after the opening event.
- R4: An activity event is a cycle with `tx_pulse` or `rx_pulse` set and `col_pulse` clear. A cycle in which `col_pulse` is also set opens no activity window.
- R5: Each event holds its window open for one full blink period (two half periods) after the most recent event. An event inside an open window extends the window without restarting the blink phase.
- R6: The duplex/collision LED is `led_n[2]` in 3-LED mode and `led_n[3]` in 4-LED mode. It is low when the link is up in full duplex. In half duplex it blinks at the collision rate while a collision window is open, and it does so even when the link is down. Otherwise it is high.
- R7: A `col_pulse` received while `full_duplex` is 1 opens no collision window.
- R8: In 3-LED mode, `led_n[3]` is held high.
- R9: In 4-LED mode, `led_n[0]` is low exactly when the link is up at 100 Mb/s, and `led_n[1]` is low exactly when the link is up at 10 Mb/s.
- R10: In 4-LED mode, `led_n[2]` is low only during the on half periods of an open activity window while the link is up.
- R11: While `link_up` is 0, every LED except the duplex/collision LED is high.
- R12: The half period is CLK_HZ/(2·rate) clock cycles. A change of a status level reaches the pins one cycle after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_4led | input | 1 | 0 selects the 3-LED mapping, 1 the 4-LED mapping |
| link_up | input | 1 | Link good level |
| speed_100 | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| full_duplex | input | 1 | 1 for full duplex, 0 for half |
| tx_pulse | input | 1 | One-cycle transmit event |
| rx_pulse | input | 1 | One-cycle receive event |
| col_pulse | input | 1 | One-cycle collision event |
| led_n | output | 4 | Active-low LED drive levels |

## Verification
A status level that changes is visible on `led_n` one cycle after the edge that samples it. An event sampled at edge t lights its blink LED from edge t+1 to edge t+HALF. The LED is then dark until edge t+2·HALF, and the steady state returns after edge t+2·HALF+1. The bench keeps a time-stamp model of each window and computes, before every edge, the value the pins must take after that edge. It compares that value one half cycle later at the falling edge, so every cycle of every window is checked at the cycle it is due. A small clock-frequency parameter makes the half periods 20 and 10 cycles.

// File: rtl/led_pkg.sv
package led_pkg;

   typedef struct packed {
      logic link;
      logic spd100;
      logic fdx;
   } port_stat_t;

   function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                               input int unsigned rate_hz);
      return clk_hz / (2 * rate_hz);
   endfunction

endpackage

// File: rtl/led_blinker.sv
// Stretch window plus blink phase for one event class.
module led_blinker #(
   parameter int unsigned HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   output logic busy,
   output logic lit
);
   localparam int unsigned PERIOD = 2 * HALF;
   localparam int unsigned WW     = $clog2(PERIOD + 1);
   localparam int unsigned HW     = $clog2(HALF + 1);

   logic [WW-1:0] win_q;
   logic [HW-1:0] hc_q;
   logic          ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
         hc_q  <= '0;
         ph_q  <= 1'b0;
      end else begin
         if (evt)
            win_q <= WW'(PERIOD);
         else if (win_q != '0)
            win_q <= win_q - 1'b1;

         if (evt && win_q == '0) begin
            ph_q <= 1'b1;
            hc_q <= '0;
         end else if (win_q != '0) begin
            if (hc_q == HW'(HALF - 1)) begin
               hc_q <= '0;
               ph_q <= ~ph_q;
            end else begin
               hc_q <= hc_q + 1'b1;
            end
         end else begin
            ph_q <= 1'b0;
            hc_q <= '0;
         end
      end
   end

   assign busy = (win_q != '0);
   assign lit  = busy & ph_q;

endmodule

// File: rtl/led_map.sv
// Mode-dependent mapping of status and blink states to LED on-levels.
module led_map
   import led_pkg::*;
(
   input  logic       mode_4led,
   input  port_stat_t stat,
   input  logic       act_busy,
   input  logic       act_lit,
   input  logic       col_lit,
   output logic [3:0] on
);
   logic fd_col;

   always_comb begin
      fd_col = (stat.link & stat.fdx) | (~stat.fdx & col_lit);
      if (mode_4led) begin
         on[0] = stat.link &  stat.spd100;
         on[1] = stat.link & ~stat.spd100;
         on[2] = stat.link &  act_lit;
         on[3] = fd_col;
      end else begin
         on[0] = stat.link & stat.spd100;
         on[1] = stat.link & (act_busy ? act_lit : 1'b1);
         on[2] = fd_col;
         on[3] = 1'b0;
      end
   end

endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl
   import led_pkg::*;
#(
   parameter int unsigned CLK_HZ = 25_000_000,
   parameter int unsigned ACT_HZ = 10,
   parameter int unsigned COL_HZ = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_4led,
   input  logic       link_up,
   input  logic       speed_100,
   input  logic       full_duplex,
   input  logic       tx_pulse,
   input  logic       rx_pulse,
   input  logic       col_pulse,
   output logic [3:0] led_n
);
   localparam int unsigned HALF_ACT = half_cycles(CLK_HZ, ACT_HZ);
   localparam int unsigned HALF_COL = half_cycles(CLK_HZ, COL_HZ);
   localparam int unsigned NCH      = 2;

   if (ACT_HZ == 0 || COL_HZ == 0 || HALF_ACT < 1 || HALF_COL < 1) begin : g_bad_rate
      $error("led_status_ctrl: blink rates must be nonzero and below CLK_HZ/2");
   end

   logic [NCH-1:0] evt, busy, lit;
   logic [3:0]     on;
   port_stat_t     stat;

   assign stat = '{link: link_up, spd100: speed_100, fdx: full_duplex};
   assign evt[0] = (tx_pulse | rx_pulse) & ~col_pulse;
   assign evt[1] = col_pulse & ~full_duplex;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam int unsigned H = (ch == 0) ? HALF_ACT : HALF_COL;
      led_blinker #(.HALF(H)) u_blink (
         .clk  (clk),
         .rst_n(rst_n),
         .evt  (evt[ch]),
         .busy (busy[ch]),
         .lit  (lit[ch])
      );
   end

   led_map u_map (
      .mode_4led(mode_4led),
      .stat     (stat),
      .act_busy (busy[0]),
      .act_lit  (lit[0]),
      .col_lit  (lit[1]),
      .on       (on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) led_n <= 4'hF;
      else        led_n <= ~on;
   end

endmodule

// File: rtl/led_status_ctrl_chk.sv
module led_status_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_4led,
   input logic       link_up,
   input logic       full_duplex,
   input logic [3:0] led_n
);
   p_rst_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (led_n == 4'hF));

   p_spare_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_4led |=> led_n[3]);

   p_one_speed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_4led |=> (led_n[0] | led_n[1]));

   p_down3_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && !mode_4led) |=> (led_n[1:0] == 2'b11));

   p_down4_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && mode_4led) |=> (led_n[2:0] == 3'b111));

   p_fdx_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (link_up && full_duplex && !mode_4led) |=> !led_n[2]);

endmodule

bind led_status_ctrl led_status_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_4led  (mode_4led),
   .link_up    (link_up),
   .full_duplex(full_duplex),
   .led_n      (led_n)
);

// File: tb/led_status_ctrl_tb.sv
`timescale 1ns/1ps
module led_status_ctrl_tb;
   localparam int unsigned CLK_HZ = 400;
   localparam int HA = 20;   // activity half period
   localparam int PA = 40;
   localparam int HC = 10;   // collision half period
   localparam int PC = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_4led = 0, link_up = 0, speed_100 = 0, full_duplex = 0;
   logic tx_pulse = 0, rx_pulse = 0, col_pulse = 0;
   logic [3:0] led_n;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 0;
   int a_last = 0, a_start = 0, c_last = 0, c_start = 0;
   bit a_have = 0, c_have = 0;

   always #2 clk = ~clk;

   led_status_ctrl #(.CLK_HZ(CLK_HZ)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_4led(mode_4led), .link_up(link_up),
      .speed_100(speed_100), .full_duplex(full_duplex), .tx_pulse(tx_pulse),
      .rx_pulse(rx_pulse), .col_pulse(col_pulse), .led_n(led_n));

   function automatic logic [3:0] want_on(bit m4, bit lk, bit sp, bit fd,
                                          bit a_open, bit a_lit, bit c_lit);
      logic [3:0] w;
      bit dc;
      dc = (lk && fd) || (!fd && c_lit);                   // R6
      if (!m4) begin
         w[0] = lk && sp;                                  // R2
         w[1] = lk && (!a_open || a_lit);                  // R3
         w[2] = dc;
         w[3] = 1'b0;                                      // R8
      end else begin
         w[0] = lk && sp;                                  // R9
         w[1] = lk && !sp;
         w[2] = lk && a_lit;                               // R10
         w[3] = dc;
      end
      return w;
   endfunction

   function automatic string tag_of(bit m4, int b);
      if (!m4) return (b == 0) ? "R2" : (b == 1) ? "R3" : (b == 2) ? "R6" : "R8";
      return (b <= 1) ? "R9" : (b == 2) ? "R10" : "R6";
   endfunction

   task automatic step(input string tag);
      int k;
      bit a_open, a_lit, c_open, c_lit, aev, cev;
      logic [3:0] exp_n;
      string t;
      k = cyc + 1;
      a_open = a_have && (k - 1 - a_last) < PA;
      a_lit  = a_open && (((k - 1 - a_start) / HA) % 2 == 0);
      c_open = c_have && (k - 1 - c_last) < PC;
      c_lit  = c_open && (((k - 1 - c_start) / HC) % 2 == 0);
      exp_n = ~want_on(mode_4led, link_up, speed_100, full_duplex, a_open, a_lit, c_lit);
      aev = (tx_pulse || rx_pulse) && !col_pulse;          // R4
      cev = col_pulse && !full_duplex;                     // R7
      if (aev) begin if (!a_open) a_start = k; a_last = k; a_have = 1; end  // R5
      if (cev) begin if (!c_open) c_start = k; c_last = k; c_have = 1; end
      @(posedge clk);
      cyc = k;
      @(negedge clk);
      checks++;
      if (led_n !== exp_n) begin
         t = tag;
         if (t == "") begin
            for (int b = 3; b >= 0; b--)
               if (led_n[b] !== exp_n[b]) t = tag_of(mode_4led, b);
         end
         errors++;
         $display("FAIL %s cycle %0d led_n=%b expected %b", t, cyc, led_n, exp_n);
      end
      tx_pulse = 0; rx_pulse = 0; col_pulse = 0;
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   initial begin
      #(400_000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      checks++;                                            // R1
      if (led_n !== 4'hF) begin
         errors++;
         $display("FAIL R1 led_n=%b expected 1111 in reset", led_n);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (led_n !== 4'hF) begin
         errors++;
         $display("FAIL R1 led_n=%b expected 1111 after release", led_n);
      end

      // 3-LED, link up 100 full duplex
      link_up = 1; speed_100 = 1; full_duplex = 1;
      step("R12");
      run(3, "");
      speed_100 = 0; step("R12");
      // single activity blink
      full_duplex = 0;
      tx_pulse = 1; step("R3");
      run(44, "R3");
      // tx together with collision: no activity, collision blinks
      tx_pulse = 1; col_pulse = 1; step("R4");
      run(25, "R4");
      // retrigger inside window
      rx_pulse = 1; step("R5");
      run(30, "R5");
      rx_pulse = 1; step("R5");
      run(60, "R5");
      // collision in full duplex ignored
      full_duplex = 1;
      col_pulse = 1; step("R7");
      run(25, "R7");
      // link down: only collision blink may show
      link_up = 0; full_duplex = 0;
      tx_pulse = 1; col_pulse = 0; step("R11");
      run(5, "R11");
      col_pulse = 1; step("R11");
      run(25, "R11");
      // 4-LED mode directed
      mode_4led = 1; link_up = 1; speed_100 = 1;
      run(3, "R9");
      rx_pulse = 1; step("R10");
      run(45, "R10");
      speed_100 = 0; col_pulse = 1; step("R6");
      run(25, "R6");

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         tx_pulse  = ($urandom_range(29) == 0);
         rx_pulse  = ($urandom_range(29) == 0);
         col_pulse = ($urandom_range(49) == 0);
         if ($urandom_range(199) == 0) link_up     = ~link_up;
         if ($urandom_range(149) == 0) speed_100   = ~speed_100;
         if ($urandom_range(149) == 0) full_duplex = ~full_duplex;
         if ($urandom_range(399) == 0) mode_4led   = ~mode_4led;
         step("");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule